// File: doc/BRIEF.md
# Serial Packet CRC Engine (5-bit and 16-bit)

This block computes and verifies the two cyclic redundancy codes that protect serial bus packets. The narrow code is five bits wide and covers the eleven-bit address/endpoint or frame-number fields of short control packets. The wide code is sixteen bits wide and covers data packet payloads of any byte count, including none. Bits arrive one per cycle, already unstuffed and in NRZ form, qualified by a valid strobe. Each covered field is presented least significant bit first.

To generate a code, the caller pulses `field_start`, feeds the field bits, and pulses `gen_go`. The engine then shifts the one's complement of its register out on `crc_bit`, most significant bit first. To check a received packet, the caller feeds the field bits followed by the received code bits in the order they arrived, then pulses `chk_end`. One cycle later the engine reports whether the register holds the fixed residual for the selected width. Both widths run on the same control sequence, and `wide_mode` picks which result is used.

Top module: `pkt_crc_engine`

## Requirements
- R1: With `wide_mode`=0, the CRC uses polynomial x^5+x^2+1 (feedback mask 5'b00101), preset to 5'b11111. After `gen_go`, `crc_bit` carries the bitwise inverse of the register, MSB first.
- R2: With `wide_mode`=1, the CRC uses polynomial x^16+x^15+x^2+1 (feedback mask 16'h8005), preset to 16'hFFFF. Payload bytes are fed LSB first, and `crc_bit` carries the inverted register, MSB first.
- R3: With `wide_mode`=0, feeding the field bits followed by the transmitted 5-bit code (MSB first) leaves the register at 5'b01100, and `crc_ok` is 1. Any single corrupted bit gives `crc_ok`=0.
- R4: `crc_bit_vld` is high for exactly 5 (narrow) or 16 (wide) consecutive cycles, starting the cycle after `gen_go`.
- R5: With `wide_mode`=1, feeding the payload followed by the transmitted 16-bit code leaves the register at 16'h800D, and `crc_ok` is 1. A corrupted bit gives `crc_ok`=0.
- R6: `crc_ok_vld` is a one-cycle pulse in the cycle after each `chk_end`, and is high at no other time.
- R7: `crc_ok` is 0 whenever `crc_ok_vld` is 0.
- R8: `field_start` presets the register to all ones. A bit presented with `bit_vld` in the same cycle as `field_start` is taken as the first bit of the new field.
- R9: `bit_in` has no effect while `bit_vld` is 0.
- R10: A zero-length wide field produces the code 16'h0000. Feeding sixteen zero bits then passes the check.
- R11: After reset, `crc_bit_vld`, `crc_ok_vld` and `crc_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 0 selects the 5-bit code, 1 selects the 16-bit code |
| field_start | input | 1 | Presets the register to all ones |
| bit_vld | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial NRZ data bit |
| chk_end | input | 1 | Requests a residual comparison |
| gen_go | input | 1 | Starts serial output of the inverted code |
| crc_bit | output | 1 | Serial code bit, MSB first |
| crc_bit_vld | output | 1 | Qualifies `crc_bit` |
| crc_ok | output | 1 | Residual matched (valid with `crc_ok_vld`) |
| crc_ok_vld | output | 1 | Check result valid |

## Verification
A wrong feedback tap or a wrong preset corrupts the register silently. It becomes visible at the ports only when the code is shifted out after `gen_go`, or when `crc_ok` drops one cycle after `chk_end`. For that reason, each field is closed by both a generate and a check sequence. A serializer that loads the wrong value, or counts the wrong length, shows up within the sixteen cycles that follow `gen_go`, as a wrong bit or a wrong run of `crc_bit_vld`. A lost preset or a leaked invalid bit is caught by comparing against a model fed only the qualified bits.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int NARROW_W = 5;
  localparam int WIDE_W   = 16;
  localparam logic [NARROW_W-1:0] NARROW_POLY  = 5'b00101;
  localparam logic [NARROW_W-1:0] NARROW_RESID = 5'b01100;
  localparam logic [WIDE_W-1:0]   WIDE_POLY    = 16'h8005;
  localparam logic [WIDE_W-1:0]   WIDE_RESID   = 16'h800D;
  localparam int LANES = 2;
  typedef enum logic {CRC_NARROW = 1'b0, CRC_WIDE = 1'b1} crc_kind_e;
endpackage

// File: rtl/crc_lane.sv
module crc_lane #(
  parameter int W = 5,
  parameter int MAXW = 16,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] RESID = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            bit_vld,
  input  logic            bit_in,
  output logic [MAXW-1:0] tx_left,
  output logic            resid_hit
);
  logic [W-1:0] crc_q;
  logic [W-1:0] base;
  logic [W-1:0] crc_d;
  logic         fb;
  logic         crc_en;

  always_comb begin
    base = start ? {W{1'b1}} : crc_q;
    fb   = bit_in ^ base[W-1];
    crc_d = base;
    if (bit_vld) begin
      crc_d = {base[W-2:0], 1'b0} ^ (fb ? POLY : {W{1'b0}});
    end
    crc_en = start | bit_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= {W{1'b1}};
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  always_comb begin
    tx_left = '0;
    tx_left[MAXW-1 -: W] = ~crc_d;
    resid_hit = (crc_d == RESID);
  end
endmodule

// File: rtl/crc_serializer.sv
module crc_serializer #(
  parameter int MAXW = 16,
  localparam int LEN_W = $clog2(MAXW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAXW-1:0]  load_val,
  input  logic [LEN_W-1:0] load_len,
  output logic             ser_bit,
  output logic             ser_vld
);
  logic [MAXW-1:0]  sh_q, sh_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             run_en;

  always_comb begin
    run_en = load | (cnt_q != '0);
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    if (load) begin
      sh_d  = load_val;
      cnt_d = load_len;
    end else if (cnt_q != '0) begin
      sh_d  = {sh_q[MAXW-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (run_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign ser_bit = sh_q[MAXW-1];
  assign ser_vld = (cnt_q != '0);
endmodule

// File: rtl/crc_verdict.sv
module crc_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_end,
  input  logic hit,
  output logic ok,
  output logic ok_vld
);
  logic ok_d, vld_d;

  always_comb begin
    vld_d = chk_end;
    ok_d  = chk_end & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok     <= 1'b0;
      ok_vld <= 1'b0;
    end else begin
      ok     <= ok_d;
      ok_vld <= vld_d;
    end
  end
endmodule

// File: rtl/pkt_crc_engine.sv
module pkt_crc_engine
  import crc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wide_mode,
  input  logic field_start,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic chk_end,
  input  logic gen_go,
  output logic crc_bit,
  output logic crc_bit_vld,
  output logic crc_ok,
  output logic crc_ok_vld
);
  localparam int MAXW  = WIDE_W;
  localparam int LEN_W = $clog2(MAXW + 1);

  logic [MAXW-1:0]  lane_tx [LANES];
  logic [LANES-1:0] lane_hit;
  crc_kind_e        kind;
  logic [MAXW-1:0]  sel_tx;
  logic [LEN_W-1:0] sel_len;
  logic             sel_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_narrow
      crc_lane #(.W(NARROW_W), .MAXW(MAXW), .POLY(NARROW_POLY), .RESID(NARROW_RESID)) u_lane (
        .clk(clk), .rst_n(rst_n), .start(field_start), .bit_vld(bit_vld), .bit_in(bit_in),
        .tx_left(lane_tx[g]), .resid_hit(lane_hit[g]));
    end else begin : g_wide
      crc_lane #(.W(WIDE_W), .MAXW(MAXW), .POLY(WIDE_POLY), .RESID(WIDE_RESID)) u_lane (
        .clk(clk), .rst_n(rst_n), .start(field_start), .bit_vld(bit_vld), .bit_in(bit_in),
        .tx_left(lane_tx[g]), .resid_hit(lane_hit[g]));
    end
  end

  always_comb begin
    kind = crc_kind_e'(wide_mode);
    if (kind == CRC_WIDE) begin
      sel_tx  = lane_tx[1];
      sel_len = LEN_W'(WIDE_W);
      sel_hit = lane_hit[1];
    end else begin
      sel_tx  = lane_tx[0];
      sel_len = LEN_W'(NARROW_W);
      sel_hit = lane_hit[0];
    end
  end

  crc_serializer #(.MAXW(MAXW)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(gen_go), .load_val(sel_tx), .load_len(sel_len),
    .ser_bit(crc_bit), .ser_vld(crc_bit_vld));

  crc_verdict u_verdict (
    .clk(clk), .rst_n(rst_n), .chk_end(chk_end), .hit(sel_hit),
    .ok(crc_ok), .ok_vld(crc_ok_vld));
endmodule

// File: rtl/pkt_crc_engine_chk.sv
module pkt_crc_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic wide_mode,
  input logic chk_end,
  input logic gen_go,
  input logic crc_bit_vld,
  input logic crc_ok,
  input logic crc_ok_vld
);
  logic [4:0] run_q;
  logic [4:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      len_q <= 5'd16;
    end else if (gen_go) begin
      run_q <= '0;
      len_q <= wide_mode ? 5'd16 : 5'd5;
    end else if (crc_bit_vld) begin
      run_q <= run_q + 1'b1;
    end
  end

  assert_ok_follows_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_end |=> crc_ok_vld);
  assert_ok_only_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok_vld |-> $past(chk_end));
  assert_ok_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_ok_vld |-> !crc_ok);
  assert_serial_begins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gen_go |=> crc_bit_vld);
  assert_serial_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bit_vld |-> (run_q < len_q));
endmodule

bind pkt_crc_engine pkt_crc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .chk_end(chk_end), .gen_go(gen_go),
  .crc_bit_vld(crc_bit_vld), .crc_ok(crc_ok), .crc_ok_vld(crc_ok_vld));

// File: tb/pkt_crc_engine_test.sv
module pkt_crc_engine_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0, field_start = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic chk_end = 1'b0, gen_go = 1'b0;
  logic crc_bit, crc_bit_vld, crc_ok, crc_ok_vld;
  logic s_bit, s_vld, s_ok, s_okv;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_crc_engine uut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .field_start(field_start),
    .bit_vld(bit_vld), .bit_in(bit_in), .chk_end(chk_end), .gen_go(gen_go),
    .crc_bit(crc_bit), .crc_bit_vld(crc_bit_vld), .crc_ok(crc_ok), .crc_ok_vld(crc_ok_vld));

  task automatic check(input bit cond, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // sample outputs (reaction to previous tick), then drive this tick's inputs
  task automatic tick(input logic st, input logic v, input logic b, input logic e, input logic g);
    @(negedge clk);
    s_bit = crc_bit; s_vld = crc_bit_vld; s_ok = crc_ok; s_okv = crc_ok_vld;
    field_start = st; bit_vld = v; bit_in = b; chk_end = e; gen_go = g;
  endtask

  function automatic logic [15:0] mstep(input logic w, input logic [15:0] s, input logic b);
    logic [15:0] r;
    if (w) begin
      r = {s[14:0], 1'b0};
      if (b ^ s[15]) r = r ^ 16'h8005;
    end else begin
      r = {11'b0, s[3:0], 1'b0};
      if (b ^ s[4]) r = r ^ 16'h0005;
    end
    return r;
  endfunction

  function automatic logic [15:0] model_tx(input logic w, input logic [63:0] v, input int n);
    logic [15:0] s = w ? 16'hFFFF : 16'h001F;
    for (int i = 0; i < n; i++) s = mstep(w, s, v[i]);
    return w ? ~s : {11'b0, ~s[4:0]};
  endfunction

  task automatic feed(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) tick(0, 1, v[i], 0, 0);
  endtask

  task automatic collect(output logic [15:0] got, output int len);
    got = '0; len = 0;
    tick(0, 0, 0, 0, 1);
    for (int k = 0; k < 20; k++) begin
      tick(0, 0, 0, 0, 0);
      if (!s_vld) break;
      got = {got[14:0], s_bit};
      len++;
    end
  endtask

  task automatic run_gen(input logic w, input logic [63:0] v, input int n, input string req);
    logic [15:0] got; int len; logic [15:0] exp;
    wide_mode = w;
    tick(1, 0, 0, 0, 0);
    feed(v, n);
    collect(got, len);
    exp = model_tx(w, v, n);
    check(got == exp, req, got, exp);
    check(len == (w ? 16 : 5), "R4", 16'(len), w ? 16'd16 : 16'd5);
  endtask

  task automatic run_chk(input logic w, input logic [63:0] v, input int n, input logic exp_ok, input string req);
    wide_mode = w;
    tick(1, 0, 0, 0, 0);
    feed(v, n);
    tick(0, 0, 0, 1, 0);
    tick(0, 0, 0, 0, 0);
    check(s_okv == 1'b1, "R6", 16'(s_okv), 16'd1);
    check(s_ok == exp_ok, req, 16'(s_ok), 16'(exp_ok));
    tick(0, 0, 0, 0, 0);
    check(s_okv == 1'b0, "R6", 16'(s_okv), 16'd0);
    check(s_ok == 1'b0, "R7", 16'(s_ok), 16'd0);
  endtask

  function automatic logic [63:0] append(input logic w, input logic [63:0] v, input int n);
    logic [15:0] c = model_tx(w, v, n);
    int cw = w ? 16 : 5;
    for (int j = 0; j < cw; j++) v[n + j] = c[cw - 1 - j];
    return v;
  endfunction

  task automatic t_reset;
    tick(0, 0, 0, 0, 0);
    check(s_vld == 0 && s_okv == 0 && s_ok == 0, "R11", {13'b0, s_vld, s_okv, s_ok}, 16'd0);
  endtask

  task automatic t_narrow;
    logic [63:0] v = 64'h0000_0000_0000_0715;
    run_gen(0, v, 11, "R1");
    run_chk(0, append(0, v, 11), 16, 1'b1, "R3");
    run_chk(0, append(0, v, 11) ^ 64'h8, 16, 1'b0, "R3");
    v = 64'h0000_0000_0000_03A2;
    run_gen(0, v, 11, "R1");
    run_chk(0, append(0, v, 11), 16, 1'b1, "R3");
  endtask

  task automatic t_wide;
    logic [63:0] v = 64'h0000_0000_C3A5_0F01;
    run_gen(1, v, 32, "R2");
    run_chk(1, append(1, v, 32), 48, 1'b1, "R5");
    run_chk(1, append(1, v, 32) ^ 64'h0000_0100_0000_0000, 48, 1'b0, "R5");
    v = 64'h0000_0000_0000_00FF;
    run_gen(1, v, 8, "R2");
    run_chk(1, append(1, v, 8), 24, 1'b1, "R5");
  endtask

  task automatic t_zero_len;
    logic [15:0] got; int len;
    wide_mode = 1;
    tick(1, 0, 0, 0, 0);
    collect(got, len);
    check(got == 16'h0000 && len == 16, "R10", got, 16'h0000);
    run_chk(1, 64'h0, 16, 1'b1, "R10");
  endtask

  task automatic t_start_with_bit;
    logic [63:0] v = 64'h0000_0000_0000_05C9;
    logic [15:0] got; int len; logic [15:0] exp;
    wide_mode = 0;
    feed(64'h5A, 7);
    tick(1, 1, v[0], 0, 0);
    for (int i = 1; i < 11; i++) tick(0, 1, v[i], 0, 0);
    collect(got, len);
    exp = model_tx(0, v, 11);
    check(got == exp, "R8", got, exp);
  endtask

  task automatic t_idle_ignored;
    logic [63:0] v = 64'h0000_0000_0000_0B3C;
    logic [15:0] got; int len; logic [15:0] exp;
    wide_mode = 1;
    tick(1, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      tick(0, 1, v[i], 0, 0);
      tick(0, 0, ~v[i], 0, 0);
      tick(0, 0, 1'b1, 0, 0);
    end
    collect(got, len);
    exp = model_tx(1, v, 16);
    check(got == exp, "R9", got, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_narrow();
    t_wide();
    t_zero_len();
    t_start_with_bit();
    t_idle_ignored();
    repeat (3) tick(0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule